// File: doc/BRIEF.md
# Register-Offset Execute Stage

This block is the execute stage of a 32-bit processor with 64 registers. It takes a 32-bit instruction word, the two source register values, the current value of the destination register, and a condition bit that an external compare unit has already worked out. It covers three instruction groups. The arithmetic group computes add, multiply, unsigned divide and NOR against a second operand. That operand is always a register plus a sign-extended 8-bit offset. The immediate group writes, or adds to the destination, a 16-bit value shifted right by a 5-bit amount. The conditional group moves src1 or writes a 0/1 flag, depending on the external condition.

The outputs are registered, so each result appears one clock after the instruction is presented. Together with the result the stage returns:
- a write-enable for the register file;
- the destination index;
- a flag for opcodes reserved inside the supported groups;
- a flag for a divide whose divisor is zero.

Opcodes outside these groups (loads, stores, branches, I/O, system) belong to other units. This stage ignores them without raising any flag.

Top module: `exe_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `wr_en`, `illegal`, `div_zero`, `wr_idx` and `result` are all zero.
- R2: Outputs change one clock after the instruction is captured: `out_valid` equals the previous cycle's `in_valid`; `wr_idx` equals instruction bits 26-21 of that instruction; with `in_valid` low, the following cycle shows `wr_en`, `illegal` and `div_zero` low.
- R3: Opcode 0x08 (bits 31-27) writes src1 + src2 + offset, modulo 2^32. The offset is instruction bits 7-0, sign-extended to 32 bits.
- R4: Opcode 0x09 writes the low 32 bits of src1 × (src2 + sign-extended offset).
- R5: Opcode 0x0a writes the unsigned quotient src1 ÷ (src2 + sign-extended offset) when that divisor is non-zero, with `div_zero` low.
- R6: Opcode 0x0a with a divisor (src2 + sign-extended offset) of zero writes 0xFFFFFFFF, raises `div_zero` and keeps `wr_en` high.
- R7: Opcode 0x0b writes the bitwise NOT of (src1 OR src2 OR sign-extended offset).
- R8: Opcode 0x10 writes the zero-extended 16-bit immediate (bits 20-5) shifted right logically by the shift amount in bits 4-0.
- R9: Opcode 0x11 writes `dst_old` plus that same shifted immediate, modulo 2^32.
- R10: Opcode 0x12 writes src1 when `cond_true` is high. When `cond_true` is low it raises no write-enable.
- R11: Opcode 0x13 always writes, with result 1 when `cond_true` is high and 0 when it is low.
- R12: Opcodes 0x0d, 0x0e, 0x0f, 0x14, 0x15 and 0x16 raise `illegal` and hold `wr_en` low.
- R13: Every other opcode (0x00-0x07, 0x0c, 0x17-0x1f) gives `wr_en`, `illegal` and `div_zero` low. Whenever `wr_en` is low, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src1_val | input | 32 | Value of the first source register |
| src2_val | input | 32 | Value of the second source register |
| dst_old | input | 32 | Current value of the destination register |
| cond_true | input | 1 | Predicate from the compare unit |
| out_valid | output | 1 | Registered copy of `in_valid` |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 6 | Destination register index |
| result | output | 32 | Value to write |
| illegal | output | 1 | Reserved opcode seen |
| div_zero | output | 1 | Divide with a zero divisor |

## Verification
The risky overlap in this block is the offset adder meeting zero-divisor detection in the same cycle. A divide whose src2 is non-zero can still have a zero divisor once the negative offset is added. The bench provokes this with src2 = 3 and offset 0xFD, alongside a plain zero src2. It judges that the flag, the all-ones result and the write strobe all appear together in the next cycle. A second overlap is one instruction's registered output appearing while the next instruction is captured. The vector walk drives instructions back to back, so any cross-talk shows up as a wrong value or a stale flag.

// File: rtl/exe_pkg.sv
package exe_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 5;

    localparam logic [OPC_W-1:0] OPC_ADD  = 5'h08;
    localparam logic [OPC_W-1:0] OPC_MUL  = 5'h09;
    localparam logic [OPC_W-1:0] OPC_DIV  = 5'h0a;
    localparam logic [OPC_W-1:0] OPC_NOR  = 5'h0b;
    localparam logic [OPC_W-1:0] OPC_MOVI = 5'h10;
    localparam logic [OPC_W-1:0] OPC_ADDI = 5'h11;
    localparam logic [OPC_W-1:0] OPC_CMOV = 5'h12;
    localparam logic [OPC_W-1:0] OPC_CMP  = 5'h13;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_ARITH = 2'd1,
        CL_MOVE  = 2'd2,
        CL_BAD   = 2'd3
    } op_class_e;

endpackage

// File: rtl/exe_decode.sv
module exe_decode
    import exe_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_e        op_class
);

    always_comb begin
        case (opcode)
            OPC_ADD, OPC_MUL, OPC_DIV, OPC_NOR:      op_class = CL_ARITH;
            OPC_MOVI, OPC_ADDI, OPC_CMOV, OPC_CMP:   op_class = CL_MOVE;
            5'h0d, 5'h0e, 5'h0f, 5'h14, 5'h15, 5'h16: op_class = CL_BAD;
            default:                                  op_class = CL_NONE;
        endcase
    end

endmodule

// File: rtl/exe_arith.sv
module exe_arith #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 8
) (
    input  logic [1:0]       sel,
    input  logic [XLEN-1:0]  src1,
    input  logic [XLEN-1:0]  src2,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  res,
    output logic             dz
);

    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] opnd_b;
    logic            b_zero;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign opnd_b  = src2 + off_ext;
    assign b_zero  = (opnd_b == '0);

    always_comb begin
        dz = 1'b0;
        case (sel)
            2'b00: res = src1 + opnd_b;
            2'b01: res = src1 * opnd_b;
            2'b10: begin
                dz  = b_zero;
                res = b_zero ? '1 : (src1 / opnd_b);
            end
            default: res = ~(src1 | src2 | off_ext);
        endcase
    end

endmodule

// File: rtl/exe_move.sv
module exe_move #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = 5
) (
    input  logic [1:0]       sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [SH_W-1:0]  shamt,
    input  logic [XLEN-1:0]  src1,
    input  logic [XLEN-1:0]  dst_old,
    input  logic             cond,
    output logic [XLEN-1:0]  res,
    output logic             we
);

    logic [XLEN-1:0] imm_sh;

    assign imm_sh = {{(XLEN-IMM_W){1'b0}}, imm} >> shamt;

    always_comb begin
        we = 1'b1;
        case (sel)
            2'b00: res = imm_sh;
            2'b01: res = dst_old + imm_sh;
            2'b10: begin
                we  = cond;
                res = src1;
            end
            default: res = {{(XLEN-1){1'b0}}, cond};
        endcase
    end

endmodule

// File: rtl/exe_unit.sv
module exe_unit
    import exe_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 6,
    parameter int OFF_W  = 8,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [XLEN-1:0]     src1_val,
    input  logic [XLEN-1:0]     src2_val,
    input  logic [XLEN-1:0]     dst_old,
    input  logic                cond_true,
    output logic                out_valid,
    output logic                wr_en,
    output logic [REG_AW-1:0]   wr_idx,
    output logic [XLEN-1:0]     result,
    output logic                illegal,
    output logic                div_zero
);

    localparam int DST_HI = INSTR_W - OPC_W - 1;

    logic [OPC_W-1:0]  op;
    logic [REG_AW-1:0] dst_f;
    logic [OFF_W-1:0]  off_f;
    logic [IMM_W-1:0]  imm_f;
    logic [SH_W-1:0]   sh_f;

    assign op    = instr[INSTR_W-1 -: OPC_W];
    assign dst_f = instr[DST_HI -: REG_AW];
    assign off_f = instr[OFF_W-1:0];
    assign imm_f = instr[SH_W +: IMM_W];
    assign sh_f  = instr[SH_W-1:0];

    op_class_e       cls;
    logic [XLEN-1:0] ar_res, mv_res;
    logic            ar_dz, mv_we;

    exe_decode u_dec (.opcode(op), .op_class(cls));

    exe_arith #(.XLEN(XLEN), .OFF_W(OFF_W)) u_arith (
        .sel(op[1:0]), .src1(src1_val), .src2(src2_val),
        .offset(off_f), .res(ar_res), .dz(ar_dz)
    );

    exe_move #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_move (
        .sel(op[1:0]), .imm(imm_f), .shamt(sh_f), .src1(src1_val),
        .dst_old(dst_old), .cond(cond_true), .res(mv_res), .we(mv_we)
    );

    logic [XLEN-1:0] nxt_res;
    logic            nxt_we, nxt_ill, nxt_dz;

    always_comb begin
        nxt_res = '0;
        nxt_we  = 1'b0;
        nxt_ill = 1'b0;
        nxt_dz  = 1'b0;
        if (in_valid) begin
            case (cls)
                CL_ARITH: begin
                    nxt_res = ar_res;
                    nxt_we  = 1'b1;
                    nxt_dz  = ar_dz;
                end
                CL_MOVE: begin
                    nxt_res = mv_we ? mv_res : '0;
                    nxt_we  = mv_we;
                end
                CL_BAD:  nxt_ill = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            result    <= '0;
            illegal   <= 1'b0;
            div_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= nxt_we;
            wr_idx    <= dst_f;
            result    <= nxt_res;
            illegal   <= nxt_ill;
            div_zero  <= nxt_dz;
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !illegal && !div_zero));

    p_divzero_allones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (wr_en && result == '1));

    p_cmov_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OPC_CMOV && !cond_true) |=> !wr_en);

    p_cmp_boolean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OPC_CMP) |=> (wr_en && result[XLEN-1:1] == '0));

    p_illegal_blocks_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !div_zero));

    p_nowrite_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (result == '0));

endmodule

// File: tb/exe_unit_tb.sv
module exe_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src1_val = '0, src2_val = '0, dst_old = '0;
    logic        cond_true = 1'b0;
    logic        out_valid, wr_en, illegal, div_zero;
    logic [5:0]  wr_idx;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exe_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src1_val(src1_val), .src2_val(src2_val), .dst_old(dst_old),
        .cond_true(cond_true), .out_valid(out_valid), .wr_en(wr_en),
        .wr_idx(wr_idx), .result(result), .illegal(illegal), .div_zero(div_zero)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] s1;
        logic [31:0] s2;
        logic [31:0] dold;
        logic        cnd;
        logic [31:0] res;
        logic        we;
        logic        ill;
        logic        dz;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VT [NV] = '{
        '{{5'h08,6'd3,6'd1,6'd2,1'b0,8'hFB}, 32'd100, 32'd20, 32'd0, 1'b0, 32'd115, 1'b1, 1'b0, 1'b0, 4'd3},       // R3
        '{{5'h08,6'd4,6'd1,6'd2,1'b0,8'h01}, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 32'd1, 1'b1, 1'b0, 1'b0, 4'd3},      // R3
        '{{5'h09,6'd5,6'd1,6'd2,1'b0,8'hFE}, 32'd7, 32'd5, 32'd0, 1'b0, 32'd21, 1'b1, 1'b0, 1'b0, 4'd4},            // R4
        '{{5'h09,6'd6,6'd1,6'd2,1'b0,8'h00}, 32'h10000, 32'h10000, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd4},     // R4
        '{{5'h0a,6'd7,6'd1,6'd2,1'b0,8'h01}, 32'd100, 32'd6, 32'd0, 1'b0, 32'd14, 1'b1, 1'b0, 1'b0, 4'd5},          // R5
        '{{5'h0a,6'd8,6'd1,6'd2,1'b0,8'h00}, 32'hFFFFFFFE, 32'd2, 32'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0, 4'd5}, // R5
        '{{5'h0a,6'd9,6'd1,6'd2,1'b0,8'hFD}, 32'd50, 32'd3, 32'd0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 4'd6},     // R6
        '{{5'h0a,6'd10,6'd1,6'd2,1'b0,8'h00}, 32'd9, 32'd0, 32'd0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 4'd6},     // R6
        '{{5'h0b,6'd11,6'd1,6'd2,1'b0,8'h00}, 32'h0F, 32'hF0, 32'd0, 1'b0, 32'hFFFFFF00, 1'b1, 1'b0, 1'b0, 4'd7},   // R7
        '{{5'h0b,6'd12,6'd1,6'd2,1'b0,8'h80}, 32'd0, 32'd0, 32'd0, 1'b0, 32'h0000007F, 1'b1, 1'b0, 1'b0, 4'd7},     // R7
        '{{5'h10,6'd13,16'hABCD,5'd4}, 32'd0, 32'd0, 32'd0, 1'b0, 32'h00000ABC, 1'b1, 1'b0, 1'b0, 4'd8},           // R8
        '{{5'h10,6'd14,16'hFFFF,5'd0}, 32'd0, 32'd0, 32'd0, 1'b0, 32'h0000FFFF, 1'b1, 1'b0, 1'b0, 4'd8},           // R8
        '{{5'h10,6'd15,16'hFFFF,5'd31}, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd8},                 // R8
        '{{5'h11,6'd16,16'h8000,5'd3}, 32'd0, 32'd0, 32'h1000, 1'b0, 32'h2000, 1'b1, 1'b0, 1'b0, 4'd9},            // R9
        '{{5'h11,6'd17,16'h0001,5'd0}, 32'd0, 32'd0, 32'hFFFFFFFF, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd9},           // R9
        '{{5'h12,6'd18,6'd1,6'd2,9'd0}, 32'hDEADBEEF, 32'd0, 32'd0, 1'b1, 32'hDEADBEEF, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
        '{{5'h12,6'd19,6'd1,6'd2,9'd0}, 32'hDEADBEEF, 32'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd10},         // R10
        '{{5'h13,6'd20,6'd1,6'd2,9'd0}, 32'h55, 32'd0, 32'd0, 1'b1, 32'd1, 1'b1, 1'b0, 1'b0, 4'd11},               // R11
        '{{5'h13,6'd21,6'd1,6'd2,9'd0}, 32'h55, 32'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd11},               // R11
        '{{5'h0d,27'd0}, 32'd1, 32'd1, 32'd0, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 4'd12},                                // R12
        '{{5'h14,27'd0}, 32'd1, 32'd1, 32'd0, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 4'd12},                                // R12
        '{{5'h16,27'd0}, 32'd1, 32'd1, 32'd0, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 4'd12},                                // R12
        '{{5'h00,27'd0}, 32'd1, 32'd0, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 4'd13},                                // R13
        '{{5'h17,27'd0}, 32'd1, 32'd0, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 4'd13},                                // R13
        '{{5'h0c,27'd0}, 32'd1, 32'd0, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 4'd13}                                 // R13
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] d, input logic c);
        in_valid  = v;
        instr     = ins;
        src1_val  = a;
        src2_val  = b;
        dst_old   = d;
        cond_true = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset, even with an instruction present
        drive(1'b1, {5'h08,27'd5}, 32'd1, 32'd2, 32'd0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
        chk("R1 result in reset", result, 32'd0);
        chk("R1 flags in reset", {30'd0, illegal, div_zero}, 32'd0);
        drive(1'b0, '0, '0, '0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {26'd0, wr_idx, out_valid, wr_en}, 32'd0);

        // table walk, back to back
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VT[i].ins, VT[i].s1, VT[i].s2, VT[i].dold, VT[i].cnd);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d result", VT[i].req, i), result, VT[i].res);
            chk($sformatf("R%0d vec%0d flags we/ill/dz", VT[i].req, i),
                {29'd0, wr_en, illegal, div_zero}, {29'd0, VT[i].we, VT[i].ill, VT[i].dz});
            // R2: valid and destination index follow the captured instruction
            chk($sformatf("R2 vec%0d valid/idx", i), {25'd0, out_valid, wr_idx},
                {25'd0, 1'b1, VT[i].ins[26:21]});
        end

        // R2: bubble with a legal opcode on the bus
        drive(1'b0, {5'h08,6'd7,21'd0}, 32'd3, 32'd4, 32'd0, 1'b1);
        @(negedge clk);
        chk("R2 bubble valid/we/flags", {29'd0, out_valid, wr_en, illegal | div_zero}, 32'd0);

        // R6 with R2: zero divisor straight after an idle cycle, then a normal add
        drive(1'b1, {5'h0a,6'd33,6'd0,6'd0,1'b0,8'hFF}, 32'd77, 32'd1, 32'd0, 1'b0);
        @(negedge clk);
        chk("R6 offset-cancelled divisor", {28'd0, out_valid, wr_en, div_zero, illegal}, 32'hE);
        drive(1'b1, {5'h08,6'd34,6'd0,6'd0,1'b0,8'h7F}, 32'd1, 32'd0, 32'd0, 1'b0);
        @(negedge clk);
        chk("R3 max positive offset", result, 32'd128);
        chk("R6 flag cleared next op", {31'd0, div_zero}, 32'd0);

        // R1: reset mid-stream clears registered outputs
        drive(1'b1, {5'h13,27'd0}, 32'd0, 32'd0, 32'd0, 1'b1);
        #1 rst_n = 1'b0;
        #1;
        chk("R1 async reset clears", {30'd0, out_valid, wr_en}, 32'd0);
        drive(1'b0, '0, '0, '0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule